// File: doc/BRIEF.md
# Wakeup Pin Interrupt Flags

This block holds one sticky interrupt flag for each of eight external wakeup pins. Every pin level is passed through a two-stage synchronizer, and its last two sampled values are compared to detect a high-to-low transition. A transition on a pin whose select bit marks it as a wakeup input sets that pin's flag. The flag then stays set until software clears it.

Software reads the flags through a byte-wide read port. It clears flags by writing a byte in which each 0 bit clears the matching flag and each 1 bit leaves it alone. Taking the interrupt does not clear any flag. A single request output is asserted while any flag is set. This output goes to the interrupt controller, which also uses it to wake the device.

Top module: `wake_flag_reg`

## Requirements
- R1: While reset is asserted, and right after it is released, all flags read 0 and the request output is low.
- R2: A high-to-low transition on a selected pin sets its flag. The flag appears on the read port at the third rising clock edge after the pin changes: two edges for synchronizing and one for the flag register.
- R3: A pin whose select bit is 0 never sets its flag, however often it toggles.
- R4: A rising transition, or a pin held at a steady level, does not set a flag.
- R5: A write clears every flag whose data bit is 0. A data bit of 1 leaves that flag unchanged. The cleared value is visible after the clock edge at which the write is sampled.
- R6: A flag stays set with no write, whatever the pins and select bits do.
- R7: If a falling edge and a clearing write reach the same flag bit in the same cycle, the flag ends up set.
- R8: Setting the select bit of a pin that is already high does not by itself set its flag.
- R9: The request output is high exactly when at least one flag is set.
- R10: Bit n of the read port is the flag for pin n, for n from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Raw levels of the external pins, not synchronized |
| wake_sel_i | input | 8 | 1 marks the pin as a wakeup input |
| wr_en_i | input | 1 | Write strobe to the flag register |
| wr_data_i | input | 8 | Write data. A 0 bit clears the matching flag |
| rd_data_o | output | 8 | Current flags |
| irq_o | output | 1 | Combined wakeup interrupt request |

## Verification
On every cycle the assertions check the following:
- a qualified edge event always lands in its flag, including when a clearing write hits the same bit;
- flags rise only where an event occurred;
- flags fall only under a 0 write bit;
- no event is raised for an unselected pin;
- the request output follows the flag byte.

Only the bench's scenarios can show two things. The first is the end-to-end latency from a raw pin transition through the synchronizer to the read port. The second is that turning on the select bit of a high pin, or driving rising edges and steady levels, produces no flag. Both depend on pin history that the assertions do not see.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  localparam int unsigned NPINS = 8;
  typedef logic [NPINS-1:0] pinvec_t;

  // qualified falling edge: previously high, now low, pin selected
  function automatic pinvec_t fall_evt(input pinvec_t prev, input pinvec_t cur,
                                       input pinvec_t sel);
    return prev & ~cur & sel;
  endfunction

  // next flag value: write-0 clears, new events always win
  function automatic pinvec_t flag_next(input pinvec_t cur, input pinvec_t evt,
                                        input logic we, input pinvec_t wd);
    pinvec_t keep;
    keep = we ? wd : '1;
    return (cur & keep) | evt;
  endfunction
endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/wkf_edge.sv
module wkf_edge
  import wkf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t cur_i,
  input  pinvec_t sel_i,
  output pinvec_t evt_o
);
  pinvec_t prev_q;

  // the previous sample tracks every pin, selected or not, so that
  // turning on a select bit never compares against a stale value
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur_i;

  assign evt_o = fall_evt(prev_q, cur_i, sel_i);
endmodule

// File: rtl/wkf_flags.sv
module wkf_flags
  import wkf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pinvec_t evt_i,
  input  logic    we_i,
  input  pinvec_t wd_i,
  output pinvec_t flags_o
);
  pinvec_t flags_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flag_next(flags_q, evt_i, we_i, wd_i);

  assign flags_o = flags_q;
endmodule

// File: rtl/wake_flag_reg.sv
module wake_flag_reg
  import wkf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] wake_sel_i,
  input  logic             wr_en_i,
  input  logic [NPINS-1:0] wr_data_i,
  output logic [NPINS-1:0] rd_data_o,
  output logic             irq_o
);
  pinvec_t pin_sync;
  pinvec_t edge_evt;
  pinvec_t flags;

  wkf_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_sync)
  );

  wkf_edge u_edge (
    .clk(clk), .rst_n(rst_n), .cur_i(pin_sync), .sel_i(wake_sel_i), .evt_o(edge_evt)
  );

  wkf_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt_i(edge_evt), .we_i(wr_en_i),
    .wd_i(wr_data_i), .flags_o(flags)
  );

  assign rd_data_o = flags;
  assign irq_o     = |flags;
endmodule

// File: rtl/wkf_chk.sv
module wkf_chk
  import wkf_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input pinvec_t sel,
  input pinvec_t evt,
  input logic    we,
  input pinvec_t wd,
  input pinvec_t rd,
  input logic    irq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |-> (rd == '0 && !irq));

  // R2
  evt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((rd & $past(evt)) == $past(evt)));

  // R3
  unselected_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~sel) == '0);

  // R5
  clear_only_by_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rd) & ~rd & ~($past(we) ? ~$past(wd) : '0)) == '0));

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ((rd & $past(rd)) == $past(rd)));

  // R7
  edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && evt != '0) |=> ((rd & $past(evt)) == $past(evt)));

  // R4
  rise_only_from_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((rd & ~$past(rd) & ~$past(evt)) == '0));

  // R9
  irq_when_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd != '0) |-> irq);

  // R9
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd == '0) |-> !irq);
endmodule

bind wake_flag_reg wkf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel(wake_sel_i), .evt(edge_evt), .we(wr_en_i),
  .wd(wr_data_i), .rd(rd_data_o), .irq(irq_o)
);

// File: tb/sim_wake_flag_reg.sv
`timescale 1ns/1ps
module sim_wake_flag_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin = 8'h00, sel = 8'h00, wd = 8'hFF;
  logic       we = 1'b0;
  logic [7:0] rd;
  logic       irq;

  int unsigned vectors = 0, errors = 0, cycles = 0;
  string       req = "R1";
  bit          done = 1'b0;

  // model state: pin sample history and flags
  bit [7:0] hist[$];
  bit [7:0] mflags;

  always #2.5 clk = ~clk;   // 200 MHz

  wake_flag_reg u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .wake_sel_i(sel),
    .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd), .irq_o(irq)
  );

  // reference model: a flag sets when the pin was seen high three samples
  // back and low two samples back (R2), pin selected now (R3, R8)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{8'h00, 8'h00, 8'h00};
      mflags = 8'h00;
    end else begin
      bit [7:0] older, newer, setv;
      older = hist[hist.size()-3];
      newer = hist[hist.size()-2];
      setv = 8'h00;
      for (int i = 0; i < 8; i++)
        if (older[i] == 1'b1 && newer[i] == 1'b0 && sel[i] == 1'b1) setv[i] = 1'b1;
      for (int i = 0; i < 8; i++)
        if (we && wd[i] == 1'b0) mflags[i] = 1'b0;     // R5
      mflags = mflags | setv;                           // R7: set wins
      hist.push_back(pin);
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  task automatic compare();
    bit exp_irq;
    exp_irq = (mflags != 8'h00);
    vectors++;
    if (rd !== mflags) begin
      errors++;
      $display("FAIL %s (R10 read port): flags=%02h expected=%02h t=%0t", req, rd, mflags, $time);
    end
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s (R9 request): irq=%0b expected=%0b t=%0t", req, irq, exp_irq, $time);
    end
  endtask

  // one cycle: check at the falling edge, then apply new inputs
  task automatic cyc(input logic [7:0] p, input logic [7:0] s,
                     input logic w, input logic [7:0] d);
    @(negedge clk);
    compare();
    pin = p; sel = s; we = w; wd = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(pin, sel, 1'b0, 8'hFF);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected<=50000", cycles);
      summary();
    end
  end

  initial begin
    // R1: reset state
    req = "R1";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    idle(3);

    // R4: steady high then rising edges only, all selected
    req = "R4";
    cyc(8'hFF, 8'hFF, 1'b0, 8'hFF);
    idle(6);

    // R2: falling edge on each pin in turn
    req = "R2";
    for (int i = 0; i < 8; i++) begin
      cyc(8'hFF & ~(8'h01 << i), 8'hFF, 1'b0, 8'hFF);
      idle(4);
      cyc(8'hFF, 8'hFF, 1'b0, 8'hFF);
      idle(3);
    end

    // R6: flags persist while pins toggle and selects change
    req = "R6";
    cyc(8'h00, 8'h00, 1'b0, 8'hFF);
    cyc(8'hFF, 8'h5A, 1'b0, 8'hFF);
    idle(5);

    // R5: clear selected bits, 1 bits untouched
    req = "R5";
    cyc(pin, sel, 1'b1, 8'hF0);
    cyc(pin, sel, 1'b1, 8'hFF);
    idle(2);
    cyc(pin, sel, 1'b1, 8'h00);
    idle(2);

    // R3: unselected pins toggle, no flag
    req = "R3";
    for (int i = 0; i < 6; i++) cyc((i % 2) ? 8'hFF : 8'h00, 8'h00, 1'b0, 8'hFF);
    idle(5);

    // R8: pins high, selects switch on
    req = "R8";
    cyc(8'hFF, 8'h00, 1'b0, 8'hFF);
    idle(5);
    cyc(8'hFF, 8'hFF, 1'b0, 8'hFF);
    idle(5);

    // R7: edge and clear reach bit 3 in the same cycle
    req = "R7";
    cyc(8'hF7, 8'hFF, 1'b0, 8'hFF);   // fall on pin 3
    cyc(pin, sel, 1'b0, 8'hFF);
    cyc(pin, sel, 1'b1, 8'h00);       // write sampled with the event
    idle(4);
    cyc(pin, sel, 1'b1, 8'h00);
    idle(2);

    // R10: mixed random traffic
    req = "R10";
    for (int i = 0; i < 400; i++)
      cyc(8'($urandom), 8'($urandom), ($urandom % 4) == 0, 8'($urandom));
    idle(5);

    summary();
  end
endmodule